// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one channel of a periodic timer. A 32-bit counter steps down by one on every tick of a selectable prescaler. When a tick arrives with the counter at zero, the counter reloads from a constant register and a sticky underflow flag is set. That flag, qualified by an enable bit, drives a level interrupt. A parent unit gates counting through the `start` input. Software reaches the channel through a word-indexed register port with four locations: reload constant, live count, control and an optional capture holding register.

The control word packs five fields: the prescaler select, a clock-edge field, an interrupt enable, a capture-enable field and two flag bits. Before a control write is applied, its field values are checked against the options built into the channel. A write with any illegal value is dropped whole and raises a sticky configuration error output. An accepted control write takes one clock cycle. During that cycle counting pauses, and it resumes on the next cycle. Changing the prescaler select clears the divide counter, so the new period starts from zero.

The register port has no handshake. A write takes effect on the clock edge where `reg_we` is high. `reg_rdata` is a combinational view of the location chosen by `reg_addr`.

Top module: `dtmr_channel`

## Requirements
- R1: After reset, the count and the reload constant read all ones. Control, capture and the underflow flag read 0, and `irq` and `cfg_err` are low.
- R2: Register index 0 is the reload constant, 1 the live count, 2 control and 3 the capture holding register. Index 3 exists only when `HAS_CAP` is 1. Without it, index 3 reads 0 and a write to it is rejected with `cfg_err`.
- R3: Control bits 2:0 choose the prescaler: codes 0, 1, 2, 3 and 4 divide the clock by 4, 16, 64, 256 and 1024. While `start` is high, the count drops by one on each prescaled tick.
- R4: A tick that finds the count at 0 loads the reload constant into the count and sets the underflow flag, which reads back in control bit 8.
- R5: While `start` is low, neither the count nor the prescaler advances.
- R6: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: An accepted control write with bit 8 equal to 0 clears the flag. With bit 8 equal to 1 the flag is kept. Bits 8 and 9 are never stored from write data, and bit 9 reads 0.
- R8: A control write is rejected if any of these holds: prescaler code 5; code 6 or 7 without `HAS_EXT`; a nonzero edge field (bits 4:3) without `HAS_EXT`; capture field (bits 7:6) equal to 1; capture field 2 or 3, or bit 9 set, without `HAS_CAP`; any bit from 10 up set. A rejected write changes nothing, including the flag, and sets `cfg_err`, which stays high until reset.
- R9: On the cycle an accepted control write is applied, no tick occurs and the prescaler holds its count. Counting continues on the next cycle.
- R10: An accepted control write that changes bits 2:0 restarts the prescaler from zero.
- R11: With `HAS_EXT` set, prescaler codes 6 and 7 and any edge field are accepted, and no internal tick is produced, so the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run gate from the parent unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data of the indexed register |
| irq | output | 1 | Underflow interrupt level |
| cfg_err | output | 1 | Sticky rejected-write indicator |

## Verification
The bench builds two copies of the channel. The first uses the default parameters (capture present, no external clock option). It is used for the divide ratios, reload, flag, pause and rejection rules. The second has the options reversed, `HAS_CAP` = 0 and `HAS_EXT` = 1. With it the bench can show that codes 6 and 7 and the edge field are accepted and leave the count frozen, and that index 3 reads 0 and its writes are rejected.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int PSC_W   = 3;
  localparam int PSC_MAX = 4;

  typedef struct packed {
    logic [1:0] cap_en;
    logic       irq_en;
    logic [1:0] edge_sel;
    logic [2:0] psc;
  } ctrl_t;

  // log2 of the divide ratio for an internal prescaler code
  function automatic logic [4:0] psc_shift(input logic [2:0] code);
    return 5'(2 * (int'(code) + 1));
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
  import dtmr_pkg::*;
#(
  parameter int MAX_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int PW = MAX_SHIFT;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;
  logic          internal;

  always_comb begin
    lim      = PW'((32'd1 << psc_shift(psc)) - 32'd1);
    internal = (int'(psc) <= PSC_MAX);
    tick     = run && internal && (pcnt == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pcnt <= '0;
    end else if (run && internal) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         uflow
);
  assign uflow = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '1;
    end else if (load_en) begin
      cnt <= load_val;
    end else if (uflow) begin
      cnt <= reload_val;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dtmr_ctrl_regs.sv
module dtmr_ctrl_regs
  import dtmr_pkg::*;
#(
  parameter int W       = 32,
  parameter bit HAS_CAP = 1'b1,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         uflow,
  output ctrl_t        ctrl_q,
  output logic [W-1:0] const_q,
  output logic [W-1:0] cap_q,
  output logic         flag_q,
  output logic         err_q,
  output logic         ctrl_wr,
  output logic         psc_chg
);
  function automatic logic ctrl_legal(input logic [W-1:0] d);
    logic ok;
    ok = 1'b1;
    if (d[2:0] == 3'd5) ok = 1'b0;
    if (d[2:0] >= 3'd6 && !HAS_EXT) ok = 1'b0;
    if (d[4:3] != 2'd0 && !HAS_EXT) ok = 1'b0;
    if (d[7:6] == 2'd1) ok = 1'b0;
    if (d[7] && !HAS_CAP) ok = 1'b0;
    if (d[9] && !HAS_CAP) ok = 1'b0;
    if (|d[W-1:10]) ok = 1'b0;
    return ok;
  endfunction

  logic ctrl_sel, cap_sel, ctrl_bad, cap_bad;

  always_comb begin
    ctrl_sel = we && (addr == 2'd2);
    cap_sel  = we && (addr == 2'd3);
    ctrl_wr  = ctrl_sel && ctrl_legal(wdata);
    ctrl_bad = ctrl_sel && !ctrl_legal(wdata);
    cap_bad  = cap_sel && !HAS_CAP;
    psc_chg  = ctrl_wr && (wdata[2:0] != ctrl_q.psc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      const_q <= '1;
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[7:0]);
      if (we && addr == 2'd0) const_q <= wdata;
      if (ctrl_wr && !wdata[8]) flag_q <= 1'b0;
      else if (uflow)           flag_q <= 1'b1;
      if (ctrl_bad || cap_bad) err_q <= 1'b1;
    end
  end

  generate
    if (HAS_CAP) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_sel) cap_q <= wdata;
      end
    end else begin : g_nocap
      assign cap_q = '0;
    end
  endgenerate
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int W         = 32,
  parameter bit HAS_CAP   = 1'b1,
  parameter bit HAS_EXT   = 1'b0,
  parameter int MAX_SHIFT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq,
  output logic         cfg_err
);
  ctrl_t        ctrl_q;
  logic [W-1:0] const_q, cap_q, cnt_q;
  logic         flag_q, ctrl_wr, psc_chg, tick, uflow, run, cnt_wr;

  assign cnt_wr = reg_we && (reg_addr == 2'd1);
  assign run    = start && !ctrl_wr;

  dtmr_ctrl_regs #(.W(W), .HAS_CAP(HAS_CAP), .HAS_EXT(HAS_EXT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .uflow(uflow), .ctrl_q(ctrl_q), .const_q(const_q), .cap_q(cap_q),
    .flag_q(flag_q), .err_q(cfg_err), .ctrl_wr(ctrl_wr), .psc_chg(psc_chg)
  );

  dtmr_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(psc_chg), .psc(ctrl_q.psc),
    .tick(tick)
  );

  dtmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(cnt_wr),
    .load_val(reg_wdata), .reload_val(const_q), .cnt(cnt_q), .uflow(uflow)
  );

  assign irq = flag_q && ctrl_q.irq_en;

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = const_q;
      2'd1: reg_rdata = cnt_q;
      2'd2: reg_rdata = W'({flag_q, ctrl_q});
      default: reg_rdata = cap_q;
    endcase
  end
endmodule

// File: rtl/dtmr_channel_chk.sv
module dtmr_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         cnt_wr,
  input logic         ctrl_wr,
  input logic         tick,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] const_q,
  input logic         flag_q,
  input logic         irq,
  input logic         cfg_err
);
  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !cnt_wr) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !cnt_wr) |=> cnt_q == $past(const_q));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0) |=> flag_q);

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cnt_wr) |=> $stable(cnt_q));

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_pause_on_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> !tick);
endmodule

bind dtmr_channel dtmr_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
  .tick(tick), .cnt_q(cnt_q), .const_q(const_q), .flag_q(flag_q), .irq(irq),
  .cfg_err(cfg_err)
);

// File: tb/tb_dtmr_channel.sv
`timescale 1ns/1ps
module tb_dtmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_x;
  logic        irq, irq_x, err, err_x;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dtmr_channel dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .cfg_err(err)
  );

  dtmr_channel #(.HAS_CAP(1'b0), .HAS_EXT(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_x), .irq(irq_x), .cfg_err(err_x)
  );

  // {accepted, control write value}
  localparam logic [32:0] VEC [12] = '{
    {1'b1, 32'h0000_0020}, {1'b1, 32'h0000_0004}, {1'b0, 32'h0000_0005},
    {1'b0, 32'h0000_0006}, {1'b0, 32'h0000_0008}, {1'b0, 32'h0000_0040},
    {1'b1, 32'h0000_0080}, {1'b1, 32'h0000_00C3}, {1'b1, 32'h0000_0200},
    {1'b0, 32'h0000_0400}, {1'b0, 32'h0001_0000}, {1'b1, 32'h0000_0100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v, output logic [31:0] vx);
    addr = a;
    #1;
    v = rdata;
    vx = rdata_x;
  endtask

  initial begin
    logic [31:0] v, vx;
    do_reset();
    // R1 reset state
    rd(2'd1, v, vx); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(2'd0, v, vx); chk("R1 const", v, 32'hFFFF_FFFF);
    rd(2'd2, v, vx); chk("R1 ctrl", v, 32'h0);
    rd(2'd3, v, vx); chk("R1 capture", v, 32'h0);
    chk("R1 irq/err", {30'd0, irq, err}, 32'h0);

    // R8 / R7: legality table
    for (int i = 0; i < 12; i++) begin
      do_reset();
      wr(2'd2, VEC[i][31:0]);
      rd(2'd2, v, vx);
      chk("R8 ctrl readback", v, VEC[i][32] ? (VEC[i][31:0] & 32'hFF) : 32'h0);
      chk("R8 err", {31'd0, err}, {31'd0, ~VEC[i][32]});
    end

    // R3: each divide ratio
    for (int p = 0; p < 5; p++) begin
      do_reset();
      wr(2'd1, 32'd7);
      wr(2'd2, 32'(p));
      start = 1'b1;
      repeat ((4 << (2 * p)) - 1) @(posedge clk);
      @(negedge clk);
      rd(2'd1, v, vx); chk("R3 before tick", v, 32'd7);
      @(posedge clk); @(negedge clk);
      rd(2'd1, v, vx); chk("R3 after tick", v, 32'd6);
    end

    // R4 / R6: underflow reload, flag and irq
    do_reset();
    wr(2'd0, 32'd3); wr(2'd1, 32'd2); wr(2'd2, 32'h20);
    start = 1'b1;
    repeat (11) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v, vx); chk("R4 count at zero", v, 32'd0);
    chk("R6 irq before underflow", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v, vx); chk("R4 reload", v, 32'd3);
    rd(2'd2, v, vx); chk("R4 flag bit 8", v, 32'h120);
    chk("R6 irq high", {31'd0, irq}, 32'd1);
    start = 1'b0;

    // R7 / R6 / R8: flag write semantics
    wr(2'd2, 32'h100);
    rd(2'd2, v, vx); chk("R7 flag kept by 1", v, 32'h100);
    chk("R6 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h005);
    rd(2'd2, v, vx); chk("R8 rejected write keeps flag", v, 32'h100);
    chk("R8 err raised", {31'd0, err}, 32'd1);
    wr(2'd2, 32'h120);
    chk("R6 irq re-enabled", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h020);
    rd(2'd2, v, vx); chk("R7 flag cleared by 0", v, 32'h020);
    chk("R7 irq low", {31'd0, irq}, 32'd0);

    // R5: stopped channel holds
    repeat (50) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v, vx); chk("R5 hold while stopped", v, 32'd3);

    // R2: register map
    wr(2'd1, 32'd9); wr(2'd3, 32'h5A5A);
    rd(2'd1, v, vx); chk("R2 count write", v, 32'd9);
    rd(2'd0, v, vx); chk("R2 const", v, 32'd3);
    rd(2'd3, v, vx); chk("R2 capture", v, 32'h5A5A);

    // R9: pause on control write
    do_reset();
    wr(2'd1, 32'd100); wr(2'd2, 32'h20);
    start = 1'b1;
    repeat (2) @(posedge clk);
    wr(2'd2, 32'h20);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v, vx); chk("R9 delayed tick", v, 32'd100);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v, vx); chk("R9 resumed tick", v, 32'd99);

    // R10: prescaler cleared on select change
    do_reset();
    wr(2'd1, 32'd100); wr(2'd2, 32'h20);
    start = 1'b1;
    repeat (2) @(posedge clk);
    wr(2'd2, 32'h21);
    repeat (15) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v, vx); chk("R10 restart before tick", v, 32'd100);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v, vx); chk("R10 first tick", v, 32'd99);

    // R11 / R2 on the variant channel
    do_reset();
    wr(2'd2, 32'h1E);
    rd(2'd2, v, vx); chk("R11 ext code accepted", vx, 32'h1E);
    chk("R11 no err", {31'd0, err_x}, 32'd0);
    wr(2'd1, 32'd5);
    start = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v, vx); chk("R11 count frozen", vx, 32'd5);
    start = 1'b0;
    wr(2'd3, 32'h1234);
    rd(2'd3, v, vx); chk("R2 absent capture reads 0", vx, 32'h0);
    chk("R2 absent capture write rejected", {31'd0, err_x}, 32'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule